// File: doc/BRIEF.md
# SCSI Controller Register and Interrupt Core

This block is the host-facing register file and command decoder of a simple SCSI bus controller. The CPU reaches it through a byte-wide register port. The block holds a 24-bit transfer counter with a start-count shadow, status, interrupt, sequence-step, FIFO-fill and configuration registers. It also holds a data FIFO and a command FIFO. It drives one interrupt line.

Host writes to the three count addresses load the start-count shadow. Any command byte that carries the DMA flag (bit 7) copies that shadow into the live counter. A command-phase input chooses which FIFO the FIFO address reaches. Only the housekeeping commands are decoded here: no-op, flush, chip reset, bus reset, transfer information and disable selection. Selection sequencing and bus phases belong to neighbouring logic.

Register offsets, as seen at `reg_addr`:

| Offset | Name | Access |
|---|---|---|
| 0 | count low | write: start bits 7:0; read: live count bits 7:0 |
| 1 | count middle | write: start bits 15:8; read: live count bits 15:8 |
| 2 | count high | write: start bits 23:16; read: live count bits 23:16, or the chip ID |
| 3 | FIFO | write: push; read: pop |
| 4 | command | read and write |
| 5 | status | read only |
| 6 | interrupt | read only, clears on read |
| 7 | sequence step | read only |
| 8 | FIFO flags | read only |
| 9 | config 1 | read and write |

Top module: `sc_reg_core`

## Requirements
- R1: The live counter is 24 bits wide. Offsets 0, 1 and 2 read its bits 7:0, 15:8 and 23:16. Writes to those offsets change only the start-count shadow, not the live counter.
- R2: A command write with bit 7 set copies the start count into the live counter. A start count of zero loads 0x010000 instead. A command without bit 7 leaves the counter unchanged. Offset 4 reads back the last command byte.
- R3: A write to offset 0, 1 or 2 clears the terminal-count bit. That bit is bit 4 of the status register at offset 5.
- R4: Offset 2 returns the CHIP_ID parameter (default 0xA2) until offset 2 has been written at least once since the last reset.
- R5: A read of offset 6 returns the interrupt register. The same read then clears that register, clears the terminal-count bit and clears the status interrupt bit (status bit 7). It also drops `irq`. The sequence step at offset 7 reads 0.
- R6: Offset 8 returns the number of bytes in the data FIFO (0 to 16) in its low 5 bits. Bits 7:5 read 0.
- R7: While the command register holds exactly 0x10 (transfer information without DMA), each FIFO write does two things. It sets interrupt bits 3 (function complete) and 4 (bus service), and it raises the interrupt.
- R8: Command opcode 0x03 (bus reset) sets interrupt bit 7 and raises the interrupt. If config 1 bit 6 is set, the command has no effect on the interrupt register or on `irq`.
- R9: Reset clears every register and both FIFOs and sets config 1 to 0x07. Reset comes either from `rst_n` low or from command opcode 0x02, which resets on the cycle it is written.
- R10: Opcode 0x01 empties the data FIFO. Opcode 0x45 clears the interrupt register and raises the interrupt.
- R11: Each FIFO holds 16 bytes in first-in first-out order. A write to a full FIFO is dropped. A read of an empty FIFO returns 0x00.
- R12: While `cmd_phase` is high, FIFO writes and reads use the command FIFO and leave the data FIFO untouched.
- R13: While the command register holds 0x90 (transfer information with DMA), a FIFO write does the following. If the live counter is zero, the write is dropped. Otherwise the byte is pushed and the counter decrements by one. When the counter reaches zero, the terminal-count bit sets.
- R14: `irq` equals the status interrupt bit. It rises when an interrupt is raised and stays high until offset 6 is read or a reset occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| reg_rdata | output | 8 | Read data, valid combinationally while reg_rd is high |
| cmd_phase | input | 1 | Sends FIFO accesses to the command FIFO |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle. They also assume that `cmd_phase` changes only between accesses. The stimulus satisfies both. Each bench access raises exactly one strobe for one cycle, and the phase input moves only on a cycle of its own. Random commands are drawn from the decoded set, and start counts are kept small so that DMA transfers reach a count of zero often.

// File: rtl/sc_reg_core_pkg.sv
// Package: offsets, opcodes and bit positions shared by the register core
// and its sub-blocks. Assumes an 8-bit register bus with a 4-bit offset.
package sc_reg_core_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned CNT_BYTES = 3;
    localparam int unsigned CNT_W = DATA_W * CNT_BYTES;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_CNT_MID = 4'd1;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_FIFO    = 4'd3;
    localparam logic [ADDR_W-1:0] OFS_CMD     = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_INTR    = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_SEQ     = 4'd7;
    localparam logic [ADDR_W-1:0] OFS_FLAGS   = 4'd8;
    localparam logic [ADDR_W-1:0] OFS_CFG1    = 4'd9;

    // Command opcodes (bits 6:0); bit 7 is the DMA flag
    localparam int unsigned CMD_DMA_BIT = 7;
    localparam logic [6:0] OP_NOP    = 7'h00;
    localparam logic [6:0] OP_FLUSH  = 7'h01;
    localparam logic [6:0] OP_CHIPRST = 7'h02;
    localparam logic [6:0] OP_BUSRST = 7'h03;
    localparam logic [6:0] OP_XFER   = 7'h10;
    localparam logic [6:0] OP_NOSEL  = 7'h45;

    // Interrupt register bits
    localparam int unsigned INT_DONE_BIT = 3;
    localparam int unsigned INT_SVC_BIT  = 4;
    localparam int unsigned INT_RST_BIT  = 7;

    // Status register bits
    localparam int unsigned ST_TC_BIT  = 4;
    localparam int unsigned ST_INT_BIT = 7;

    // Config 1 bits and reset value
    localparam int unsigned CFG_NORPT_BIT = 6;
    localparam logic [DATA_W-1:0] CFG1_RESET = 8'h07;

    // Live counter value loaded for a zero start count
    localparam logic [CNT_W-1:0] CNT_ZERO_LOAD = 24'h010000;

endpackage

// File: rtl/sc_byte_fifo.sv
// Byte FIFO with drop-on-full and zero-on-empty semantics.
// Assumes push and pop are not both requested in one cycle (single-port bus);
// if they are, both take effect. dout shows the head entry, or 0 when empty.
module sc_byte_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic             full;
    logic             empty;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? '0 : mem[rd_ptr];

    // Storage write: only accepted pushes land in the array
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and fill-level upkeep
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    assert_fill_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (count == CW'(DEPTH)));

    assert_empty_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (dout == '0));

endmodule

// File: rtl/sc_xfer_counter.sv
// Transfer counter: a start-count shadow loaded byte by byte from the bus,
// and a live counter reloaded from it or decremented by the DMA path.
// Assumes reload and dec are never both high in one cycle.
module sc_xfer_counter
    import sc_reg_core_pkg::*;
#(
    parameter int unsigned BYTES = CNT_BYTES,
    localparam int unsigned W = DATA_W * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTES-1:0]  wr_byte,
    input  logic [DATA_W-1:0] wdata,
    input  logic              reload,
    input  logic              dec,
    output logic [W-1:0]      count,
    output logic              hi_written
);

    logic [W-1:0] start_q;

    // Start-count shadow: one byte lane per count offset
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q[DATA_W*b +: DATA_W] <= '0;
            end else if (wr_byte[b]) begin
                start_q[DATA_W*b +: DATA_W] <= wdata;
            end
        end
    end

    // Live counter: reload from shadow (zero maps to the zero-load value) or count down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (reload) begin
            count <= (start_q == '0) ? W'(CNT_ZERO_LOAD) : start_q;
        end else if (dec) begin
            count <= count - 1'b1;
        end
    end

    // Marks the top byte as written so the chip ID stops showing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_written <= 1'b0;
        end else if (wr_byte[BYTES-1]) begin
            hi_written <= 1'b1;
        end
    end

    assert_reload_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (count == (($past(start_q) == '0) ? W'(CNT_ZERO_LOAD) : $past(start_q))));

    assert_shadow_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wr_byte) && !reload && !dec) |=> $stable(count));

endmodule

// File: rtl/sc_reg_core.sv
// Register and interrupt core of a SCSI bus controller, seen from the host.
// Decodes register reads and writes and the housekeeping commands, keeps the
// status and interrupt state, and routes FIFO traffic by cmd_phase.
// Assumes reg_wr and reg_rd are mutually exclusive and that read side
// effects happen at the clock edge that ends the read cycle.
module sc_reg_core
    import sc_reg_core_pkg::*;
#(
    parameter int unsigned DATA_DEPTH = 16,
    parameter int unsigned CMD_DEPTH  = 16,
    parameter logic [7:0]  CHIP_ID    = 8'hA2,
    localparam int unsigned DCW = $clog2(DATA_DEPTH + 1),
    localparam int unsigned CCW = $clog2(CMD_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_rd,
    output logic [7:0] reg_rdata,
    input  logic       cmd_phase,
    output logic       irq
);

    logic [DATA_W-1:0] cmd_q;
    logic [DATA_W-1:0] intr_q;
    logic [DATA_W-1:0] cfg1_q;
    logic              tc_q;
    logic              int_q;

    logic              cmd_wr;
    logic [6:0]        opcode;
    logic              soft_rst;
    logic              core_rst_n;
    logic              cnt_wr;
    logic [CNT_BYTES-1:0] cnt_byte_wr;
    logic              fifo_wr;
    logic              fifo_rd;
    logic              xfer_dma;
    logic              xfer_pio;
    logic              dma_stall;
    logic              fifo_accept;
    logic              cnt_dec;
    logic              intr_rd;

    logic [CNT_W-1:0]  live_cnt;
    logic              hi_written;
    logic [DATA_W-1:0] data_dout;
    logic [DATA_W-1:0] cmdf_dout;
    logic [DCW-1:0]    data_cnt;
    logic [CCW-1:0]    cmdf_cnt;

    // Access decode
    assign cmd_wr      = reg_wr && (reg_addr == OFS_CMD);
    assign opcode      = reg_wdata[6:0];
    assign soft_rst    = cmd_wr && (opcode == OP_CHIPRST);
    assign core_rst_n  = rst_n && !soft_rst;
    assign cnt_byte_wr = {reg_wr && (reg_addr == OFS_CNT_HI),
                          reg_wr && (reg_addr == OFS_CNT_MID),
                          reg_wr && (reg_addr == OFS_CNT_LO)};
    assign cnt_wr      = |cnt_byte_wr;
    assign fifo_wr     = reg_wr && (reg_addr == OFS_FIFO);
    assign fifo_rd     = reg_rd && (reg_addr == OFS_FIFO);
    assign intr_rd     = reg_rd && (reg_addr == OFS_INTR);

    // Transfer-mode qualifiers on the held command byte
    assign xfer_dma    = (cmd_q == {1'b1, OP_XFER});
    assign xfer_pio    = (cmd_q == {1'b0, OP_XFER});
    assign dma_stall   = xfer_dma && (live_cnt == '0);
    assign fifo_accept = fifo_wr && !dma_stall;
    assign cnt_dec     = fifo_wr && xfer_dma && (live_cnt != '0);

    sc_xfer_counter #(
        .BYTES(CNT_BYTES)
    ) u_counter (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .wr_byte   (cnt_byte_wr),
        .wdata     (reg_wdata),
        .reload    (cmd_wr && reg_wdata[CMD_DMA_BIT] && !soft_rst),
        .dec       (cnt_dec),
        .count     (live_cnt),
        .hi_written(hi_written)
    );

    sc_byte_fifo #(
        .DEPTH(DATA_DEPTH),
        .WIDTH(DATA_W)
    ) u_data_fifo (
        .clk  (clk),
        .rst_n(core_rst_n),
        .clr  (cmd_wr && (opcode == OP_FLUSH)),
        .push (fifo_accept && !cmd_phase),
        .din  (reg_wdata),
        .pop  (fifo_rd && !cmd_phase),
        .dout (data_dout),
        .count(data_cnt)
    );

    sc_byte_fifo #(
        .DEPTH(CMD_DEPTH),
        .WIDTH(DATA_W)
    ) u_cmd_fifo (
        .clk  (clk),
        .rst_n(core_rst_n),
        .clr  (1'b0),
        .push (fifo_accept && cmd_phase),
        .din  (reg_wdata),
        .pop  (fifo_rd && cmd_phase),
        .dout (cmdf_dout),
        .count(cmdf_cnt)
    );

    // Command, status, interrupt and config state
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            cmd_q  <= '0;
            intr_q <= '0;
            cfg1_q <= CFG1_RESET;
            tc_q   <= 1'b0;
            int_q  <= 1'b0;
        end else begin
            if (intr_rd) begin
                intr_q <= '0;
                tc_q   <= 1'b0;
                int_q  <= 1'b0;
            end
            if (cnt_wr) begin
                tc_q <= 1'b0;
            end
            if (cnt_dec && (live_cnt == CNT_W'(1))) begin
                tc_q <= 1'b1;
            end
            if (fifo_wr && xfer_pio) begin
                intr_q[INT_DONE_BIT] <= 1'b1;
                intr_q[INT_SVC_BIT]  <= 1'b1;
                int_q <= 1'b1;
            end
            if (cmd_wr) begin
                cmd_q <= reg_wdata;
                if (opcode == OP_BUSRST && !cfg1_q[CFG_NORPT_BIT]) begin
                    intr_q[INT_RST_BIT] <= 1'b1;
                    int_q <= 1'b1;
                end
                if (opcode == OP_NOSEL) begin
                    intr_q <= '0;
                    int_q  <= 1'b1;
                end
            end
            if (reg_wr && (reg_addr == OFS_CFG1)) begin
                cfg1_q <= reg_wdata;
            end
        end
    end

    assign irq = int_q;

    // Read-data multiplexer
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CNT_LO:  reg_rdata = live_cnt[7:0];
            OFS_CNT_MID: reg_rdata = live_cnt[15:8];
            OFS_CNT_HI:  reg_rdata = hi_written ? live_cnt[23:16] : CHIP_ID;
            OFS_FIFO:    reg_rdata = cmd_phase ? cmdf_dout : data_dout;
            OFS_CMD:     reg_rdata = cmd_q;
            OFS_STATUS:  reg_rdata = {int_q, 2'b00, tc_q, 4'b0000};
            OFS_INTR:    reg_rdata = intr_q;
            OFS_FLAGS:   reg_rdata = DATA_W'(data_cnt);
            OFS_CFG1:    reg_rdata = cfg1_q;
            default:     reg_rdata = '0;
        endcase
    end

    assert_intr_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_rd && !reg_wr) |=> (intr_q == '0 && !irq && !tc_q));

    assert_count_write_clears_tc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> !tc_q);

    assert_busrst_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && opcode == OP_BUSRST && cfg1_q[CFG_NORPT_BIT]) |=> ($stable(intr_q) && $stable(irq)));

    assert_irq_holds_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !intr_rd && !soft_rst) |=> irq);

    assert_chip_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cfg1_q == CFG1_RESET && !irq && data_cnt == '0 && cmdf_cnt == '0));

    assert_pio_write_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && xfer_pio) |=> (irq && intr_q[INT_DONE_BIT] && intr_q[INT_SVC_BIT]));

    assert_phase_isolation_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((fifo_wr || fifo_rd) && cmd_phase) |=> $stable(data_cnt));

endmodule

// File: tb/test_sc_reg_core.sv
// Self-checking bench: directed corners then seeded random traffic, every
// read compared with a behavioural model of the register map.
module test_sc_reg_core;

    localparam logic [7:0] CHIP_ID = 8'hA2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       cmd_phase = 1'b0;
    logic       irq;

    always #4 clk = ~clk;

    sc_reg_core #(.DATA_DEPTH(16), .CMD_DEPTH(16), .CHIP_ID(CHIP_ID)) i_sc_reg_core (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .cmd_phase(cmd_phase), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural model
    logic [23:0] m_start, m_cnt;
    logic        m_hiwr, m_tc, m_int;
    logic [7:0]  m_intr, m_cmd, m_cfg;
    logic [7:0]  dq [16];
    logic [7:0]  cq [16];
    int          dn, cn;

    task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_start = '0; m_cnt = '0; m_hiwr = 0; m_tc = 0; m_int = 0;
        m_intr = '0; m_cmd = '0; m_cfg = 8'h07; dn = 0; cn = 0;
    endtask

    task automatic model_push(input logic [7:0] d);
        if (cmd_phase) begin
            if (cn < 16) begin cq[cn] = d; cn++; end
        end else begin
            if (dn < 16) begin dq[dn] = d; dn++; end
        end
    endtask

    function automatic logic [7:0] model_pop();
        logic [7:0] v;
        v = 8'h00;
        if (cmd_phase) begin
            if (cn > 0) begin
                v = cq[0];
                for (int i = 0; i < 15; i++) cq[i] = cq[i+1];
                cn--;
            end
        end else begin
            if (dn > 0) begin
                v = dq[0];
                for (int i = 0; i < 15; i++) dq[i] = dq[i+1];
                dn--;
            end
        end
        return v;
    endfunction

    task automatic model_write(input logic [3:0] a, input logic [7:0] d);
        case (a)
            4'd0: begin m_start[7:0] = d; m_tc = 0; end
            4'd1: begin m_start[15:8] = d; m_tc = 0; end
            4'd2: begin m_start[23:16] = d; m_hiwr = 1; m_tc = 0; end
            4'd3: begin
                if (m_cmd == 8'h90) begin
                    if (m_cnt != 0) begin
                        model_push(d);
                        m_cnt--;
                        if (m_cnt == 0) m_tc = 1;
                    end
                end else begin
                    model_push(d);
                    if (m_cmd == 8'h10) begin m_intr |= 8'h18; m_int = 1; end
                end
            end
            4'd4: begin
                if (d[6:0] == 7'h02) model_reset();
                else begin
                    m_cmd = d;
                    if (d[7]) m_cnt = (m_start == 0) ? 24'h010000 : m_start;
                    if (d[6:0] == 7'h01) dn = 0;
                    if (d[6:0] == 7'h03 && !m_cfg[6]) begin m_intr[7] = 1; m_int = 1; end
                    if (d[6:0] == 7'h45) begin m_intr = 0; m_int = 1; end
                end
            end
            4'd9: m_cfg = d;
            default: ;
        endcase
    endtask

    function automatic string req_of(input logic [3:0] a);
        case (a)
            4'd0, 4'd1: return "R1";
            4'd2: return "R4";
            4'd3: return cmd_phase ? "R12" : "R11";
            4'd4: return "R2";
            4'd5: return "R3";
            4'd6: return "R5";
            4'd8: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic irq_check();
        @(negedge clk);
        check8("R14", "irq", {7'd0, irq}, {7'd0, m_int});
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        model_write(a, d);
        @(posedge clk);
        #1 reg_wr = 1'b0;
        irq_check();
    endtask

    task automatic rd(input logic [3:0] a, input string req);
        logic [7:0] got, exp;
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #2 got = reg_rdata;
        case (a)
            4'd0: exp = m_cnt[7:0];
            4'd1: exp = m_cnt[15:8];
            4'd2: exp = m_hiwr ? m_cnt[23:16] : CHIP_ID;
            4'd3: exp = model_pop();
            4'd4: exp = m_cmd;
            4'd5: exp = {m_int, 2'b00, m_tc, 4'b0000};
            4'd6: begin exp = m_intr; m_intr = 0; m_tc = 0; m_int = 0; end
            4'd8: exp = 8'(dn);
            4'd9: exp = m_cfg;
            default: exp = 8'h00;
        endcase
        check8(req, $sformatf("read offset %0d", a), got, exp);
        @(posedge clk);
        #1 reg_rd = 1'b0;
        irq_check();
    endtask

    task automatic set_phase(input logic p);
        @(negedge clk);
        cmd_phase = p;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R14 watchdog actual=running expected=finished");
            summary();
        end
    end

    // Stimulus
    initial begin
        logic [7:0] cmds [10];
        cmds = '{8'h00, 8'h01, 8'h03, 8'h10, 8'h45, 8'h80, 8'h90, 8'h90, 8'h10, 8'h02};
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state, chip ID (R9, R4)
        for (int a = 0; a < 10; a++) rd(4'(a), (a == 2) ? "R4" : "R9");

        // Reload from shadow; shadow writes do not touch live count (R1, R2)
        wr(4'd0, 8'h05); wr(4'd1, 8'h01);
        rd(4'd0, "R1");
        wr(4'd4, 8'h80);
        rd(4'd0, "R2"); rd(4'd1, "R2"); rd(4'd2, "R4");
        wr(4'd2, 8'h00); rd(4'd2, "R4");

        // Zero start loads 0x010000; non-DMA command keeps count (R2)
        wr(4'd0, 8'h00); wr(4'd1, 8'h00); wr(4'd4, 8'h80);
        rd(4'd0, "R2"); rd(4'd1, "R2"); rd(4'd2, "R2");
        wr(4'd0, 8'h03); wr(4'd4, 8'h00); rd(4'd0, "R2"); rd(4'd2, "R2");

        // FIFO overflow and empty read (R11, R6)
        for (int i = 0; i < 17; i++) wr(4'd3, 8'(i + 8'h30));
        rd(4'd8, "R6");
        for (int i = 0; i < 17; i++) rd(4'd3, "R11");
        rd(4'd8, "R6");

        // Non-DMA transfer: write raises done+service (R7, R5)
        wr(4'd4, 8'h10); wr(4'd3, 8'h77);
        rd(4'd5, "R7"); rd(4'd6, "R7"); rd(4'd7, "R5"); rd(4'd5, "R5");

        // Bus reset reported, then masked by config bit 6 (R8)
        wr(4'd4, 8'h03); rd(4'd6, "R8");
        wr(4'd9, 8'h47); wr(4'd4, 8'h03); rd(4'd6, "R8"); rd(4'd5, "R8");

        // DMA transfer: count down, terminal count, stall at zero (R13, R3)
        wr(4'd4, 8'h01); wr(4'd0, 8'h02); wr(4'd2, 8'h00); wr(4'd4, 8'h90);
        wr(4'd3, 8'hA1); wr(4'd3, 8'hA2); wr(4'd3, 8'hA3);
        rd(4'd5, "R13"); rd(4'd8, "R13"); rd(4'd0, "R13");
        wr(4'd1, 8'h00); rd(4'd5, "R3");

        // Command phase routing (R12)
        wr(4'd4, 8'h00);
        set_phase(1'b1);
        wr(4'd3, 8'hC1); wr(4'd3, 8'hC2);
        rd(4'd8, "R12"); rd(4'd3, "R12"); rd(4'd3, "R12"); rd(4'd3, "R12");
        set_phase(1'b0);

        // Disable-selection and flush (R10)
        wr(4'd4, 8'h03); wr(4'd9, 8'h07); wr(4'd4, 8'h03);
        wr(4'd4, 8'h45); rd(4'd5, "R10"); rd(4'd6, "R10");
        wr(4'd3, 8'h11); wr(4'd4, 8'h01); rd(4'd8, "R10");

        // Chip reset command (R9)
        wr(4'd9, 8'h55); wr(4'd2, 8'h01); wr(4'd3, 8'h22); wr(4'd4, 8'h03);
        wr(4'd4, 8'h02);
        rd(4'd9, "R9"); rd(4'd2, "R9"); rd(4'd8, "R9"); rd(4'd6, "R9");

        // Seeded random traffic checked against the model
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = $urandom_range(0, 19);
            case (op)
                0, 1:  wr(4'd0, 8'($urandom_range(0, 3)));
                2:     wr(4'd1, ($urandom_range(0, 7) == 0) ? 8'h01 : 8'h00);
                3:     wr(4'd2, ($urandom_range(0, 7) == 0) ? 8'h02 : 8'h00);
                4, 5, 6: wr(4'd3, 8'($urandom));
                7, 8:  rd(4'd3, cmd_phase ? "R12" : "R11");
                9, 10: wr(4'd4, cmds[$urandom_range(0, ($urandom_range(0, 9) == 0) ? 9 : 8)]);
                11, 12, 13: begin
                    logic [3:0] a;
                    a = 4'($urandom_range(0, 15));
                    rd(a, req_of(a));
                end
                14:    wr(4'd9, ($urandom_range(0, 1) == 0) ? 8'h47 : 8'h07);
                15, 16: rd(4'd6, "R5");
                17:    rd(4'd5, "R13");
                18:    rd(4'd8, "R6");
                default: if ($urandom_range(0, 3) == 0) set_phase(~cmd_phase);
            endcase
        end

        done = 1'b1;
        summary();
    end

endmodule